// File: doc/BRIEF.md
# Digital Linear Ramp Generator

This block sweeps a 32-bit control word linearly between two programmable limits. The word drives the frequency, phase or amplitude input of an oscillator that sits outside the block. An external direction pin chooses between the rising and the falling ramp. Each direction has its own step size and its own clock divider, so the rate of change in a direction is its step size times the system clock divided by (divider + 1).

Each limit has its own dwell flag. With the flag set, the ramp waits at that limit until the direction pin changes. With the flag clear, the ramp turns around at that limit without waiting for the pin. Clearing both flags gives a continuous triangle. Other combinations give single-shot sweeps that start on a pin transition. Software programs the block through a simple write port. The destination select holds one destination at a time, and enabling a destination replaces the previous one.

Top module: `ramp_gen`

## Requirements
- R1: After synchronous reset, `ramp_word` is 0, `ramp_active` is 0, `dest_tag` is 0 and `amp_code` is 0.
- R2: A write to address 7 with bit 2 set and a destination code in bits [1:0] enables the block and makes that code `dest_tag` from the next cycle on. The codes are 0 for frequency, 1 for phase and 2 for amplitude. Code 3 is ignored. An enable replaces any earlier destination.
- R3: A write to address 7 with bit 2 clear disables the block only if bits [1:0] equal the current destination. If they name a different destination, the write has no effect.
- R4: While rising, the word advances by the rising step (address 2) once every (rising divider + 1) cycles (address 4).
- R5: While falling, the word decreases by the falling step (address 3) once every (falling divider + 1) cycles (address 5).
- R6: A step is clamped so that the word never goes below the lower limit (address 0) or above the upper limit (address 1).
- R7: When the dwell flag of a limit is set (address 6: bit 0 for the upper limit, bit 1 for the lower limit), the word holds at that limit until the synchronised direction pin changes.
- R8: When the dwell flag of a limit is clear, the ramp turns around at that limit by itself.
- R9: With both dwell flags clear, the word runs as a continuous triangle between the two limits.
- R10: A high direction pin selects the rising ramp and a low pin selects the falling ramp. The pin passes through a two-flop synchroniser. While the block is disabled, the ramp direction follows the pin level.
- R11: `amp_code` equals bits [31:18] of the word when the destination is amplitude, and 0 otherwise.
- R12: While the block is disabled, the word is loaded with the lower limit on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| dir_pin | input | 1 | Asynchronous ramp direction pin (1 = rising) |
| ramp_word | output | 32 | Current ramp word |
| dest_tag | output | 2 | Destination of the ramp word |
| ramp_active | output | 1 | Block enabled |
| amp_code | output | 14 | Amplitude code taken from the top of the ramp word |

## Verification
The hardest situation to reach is a turnaround or dwell decision that lands in the same cycle as a divider tick or a pin edge. In that cycle the clamp, the reversal and the pin synchroniser all act at once. Directed sweeps with small dividers push the word to each limit under every dwell combination. Constrained random runs then use random limits, steps, dividers and dwell flags, toggle the pin at random times and issue stray disables. A cycle-accurate reference model in the bench is compared against the outputs on every cycle.

// File: rtl/ramp_gen_pkg.sv
package ramp_gen_pkg;
    localparam int RAMP_W = 32;
    localparam int DIV_W  = 16;
    localparam int AMP_W  = 14;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_LOWER = 3'd0;
    localparam logic [ADDR_W-1:0] A_UPPER = 3'd1;
    localparam logic [ADDR_W-1:0] A_RSTEP = 3'd2;
    localparam logic [ADDR_W-1:0] A_FSTEP = 3'd3;
    localparam logic [ADDR_W-1:0] A_RDIV  = 3'd4;
    localparam logic [ADDR_W-1:0] A_FDIV  = 3'd5;
    localparam logic [ADDR_W-1:0] A_DWELL = 3'd6;
    localparam logic [ADDR_W-1:0] A_SEL   = 3'd7;

    typedef enum logic [1:0] {
        DEST_FREQ  = 2'd0,
        DEST_PHASE = 2'd1,
        DEST_AMP   = 2'd2
    } dest_e;

    typedef struct packed {
        logic [RAMP_W-1:0] lower;
        logic [RAMP_W-1:0] upper;
        logic [RAMP_W-1:0] rise_step;
        logic [RAMP_W-1:0] fall_step;
        logic [DIV_W-1:0]  rise_div;
        logic [DIV_W-1:0]  fall_div;
        logic              hold_hi;
        logic              hold_lo;
    } cfg_t;

    // Advance toward the upper limit without passing it.
    function automatic logic [RAMP_W-1:0] clamp_up(
        input logic [RAMP_W-1:0] cur,
        input logic [RAMP_W-1:0] step,
        input logic [RAMP_W-1:0] hi);
        if (cur >= hi || (hi - cur) <= step)
            return hi;
        return cur + step;
    endfunction

    // Retreat toward the lower limit without passing it.
    function automatic logic [RAMP_W-1:0] clamp_down(
        input logic [RAMP_W-1:0] cur,
        input logic [RAMP_W-1:0] step,
        input logic [RAMP_W-1:0] lo);
        if (cur <= lo || (cur - lo) <= step)
            return lo;
        return cur - step;
    endfunction
endpackage

// File: rtl/ramp_regs.sv
module ramp_regs
    import ramp_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [RAMP_W-1:0] wr_data,
    output cfg_t              cfg,
    output logic              active,
    output dest_e             dest
);
    logic       code_ok;
    logic [1:0] code;

    assign code    = wr_data[1:0];
    assign code_ok = (code != 2'd3);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            active <= 1'b0;
            dest   <= DEST_FREQ;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_LOWER: cfg.lower     <= wr_data;
                A_UPPER: cfg.upper     <= wr_data;
                A_RSTEP: cfg.rise_step <= wr_data;
                A_FSTEP: cfg.fall_step <= wr_data;
                A_RDIV:  cfg.rise_div  <= wr_data[DIV_W-1:0];
                A_FDIV:  cfg.fall_div  <= wr_data[DIV_W-1:0];
                A_DWELL: begin
                    cfg.hold_hi <= wr_data[0];
                    cfg.hold_lo <= wr_data[1];
                end
                A_SEL: begin
                    if (code_ok && wr_data[2]) begin
                        active <= 1'b1;
                        dest   <= dest_e'(code);
                    end else if (code_ok && code == dest) begin
                        active <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ramp_tick.sv
module ramp_tick
    import ramp_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt == div)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ramp_dir_sync.sv
module ramp_dir_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic edge_seen
);
    logic s1, s2, prev;

    assign level     = s2;
    assign edge_seen = s2 ^ prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            prev <= 1'b0;
        end else begin
            s1   <= pin;
            s2   <= s1;
            prev <= s2;
        end
    end
endmodule

// File: rtl/ramp_core.sv
module ramp_core
    import ramp_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  cfg_t              cfg,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              dir_level,
    input  logic              dir_edge,
    output logic [RAMP_W-1:0] word
);
    logic going_up;
    logic at_hi, at_lo;

    assign at_hi = (word == cfg.upper);
    assign at_lo = (word == cfg.lower);

    always_ff @(posedge clk) begin
        if (rst) begin
            word     <= '0;
            going_up <= 1'b0;
        end else if (!active) begin
            word     <= cfg.lower;
            going_up <= dir_level;
        end else begin
            if (going_up && rise_tick)
                word <= clamp_up(word, cfg.rise_step, cfg.upper);
            else if (!going_up && fall_tick)
                word <= clamp_down(word, cfg.fall_step, cfg.lower);

            if (dir_edge)
                going_up <= dir_level;
            else if (going_up && at_hi && !cfg.hold_hi)
                going_up <= 1'b0;
            else if (!going_up && at_lo && !cfg.hold_lo)
                going_up <= 1'b1;
        end
    end
endmodule

// File: rtl/ramp_gen.sv
module ramp_gen
    import ramp_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [RAMP_W-1:0] wr_data,
    input  logic              dir_pin,
    output logic [RAMP_W-1:0] ramp_word,
    output logic [1:0]        dest_tag,
    output logic              ramp_active,
    output logic [AMP_W-1:0]  amp_code
);
    localparam int N_DIR = 2;

    cfg_t             cfg;
    logic             active;
    dest_e            dest;
    logic             dir_level, dir_edge;
    logic [DIV_W-1:0] divs  [N_DIR];
    logic [N_DIR-1:0] ticks;

    ramp_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg(cfg), .active(active), .dest(dest)
    );

    ramp_dir_sync u_sync (
        .clk(clk), .rst(rst), .pin(dir_pin),
        .level(dir_level), .edge_seen(dir_edge)
    );

    assign divs[0] = cfg.rise_div;
    assign divs[1] = cfg.fall_div;

    for (genvar g = 0; g < N_DIR; g++) begin : g_tick
        ramp_tick u_tick (
            .clk(clk), .rst(rst), .run(active),
            .div(divs[g]), .tick(ticks[g])
        );
    end

    ramp_core u_core (
        .clk(clk), .rst(rst), .active(active), .cfg(cfg),
        .rise_tick(ticks[0]), .fall_tick(ticks[1]),
        .dir_level(dir_level), .dir_edge(dir_edge), .word(ramp_word)
    );

    assign dest_tag    = dest;
    assign ramp_active = active;
    assign amp_code    = (dest == DEST_AMP) ? ramp_word[RAMP_W-1 -: AMP_W] : '0;
endmodule

// File: rtl/ramp_gen_checker.sv
module ramp_gen_checker
    import ramp_gen_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [RAMP_W-1:0] wr_data,
    input logic [RAMP_W-1:0] word,
    input logic [1:0]        tag,
    input logic              active,
    input logic [RAMP_W-1:0] lo,
    input logic [RAMP_W-1:0] hi,
    input logic [RAMP_W-1:0] rstep,
    input logic [RAMP_W-1:0] fstep
);
    logic sel_wr;
    assign sel_wr = wr_en && (wr_addr == A_SEL) && (wr_data[1:0] != 2'd3);

    assert_enable_dest_R2: assert property (@(posedge clk) disable iff (rst)
        (sel_wr && wr_data[2]) |=> (active && tag == $past(wr_data[1:0])));

    assert_foreign_disable_R3: assert property (@(posedge clk) disable iff (rst)
        (sel_wr && !wr_data[2] && active && wr_data[1:0] != tag)
        |=> (active && $stable(tag)));

    assert_rise_step_R4: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && $stable(lo) && $stable(hi) && word > $past(word))
        |-> ((word - $past(word)) <= $past(rstep)));

    assert_fall_step_R5: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && $stable(lo) && $stable(hi) && word < $past(word))
        |-> (($past(word) - word) <= $past(fstep)));

    assert_within_limits_R6: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && $stable(lo) && $stable(hi) && lo <= hi
         && $past(word) >= lo && $past(word) <= hi)
        |-> (word >= lo && word <= hi));

    assert_idle_lower_R12: assert property (@(posedge clk) disable iff (rst)
        !active |=> (word == $past(lo)));
endmodule

bind ramp_gen ramp_gen_checker u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .word(ramp_word), .tag(dest_tag), .active(ramp_active),
    .lo(cfg.lower), .hi(cfg.upper), .rstep(cfg.rise_step), .fstep(cfg.fall_step)
);

// File: tb/tb_ramp_gen.sv
module tb_ramp_gen;
    import ramp_gen_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [RAMP_W-1:0] wr_data = '0;
    logic              dir_pin = 1'b0;
    logic [RAMP_W-1:0] ramp_word;
    logic [1:0]        dest_tag;
    logic              ramp_active;
    logic [AMP_W-1:0]  amp_code;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 0;

    always #5 clk = ~clk;

    ramp_gen dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dir_pin(dir_pin), .ramp_word(ramp_word), .dest_tag(dest_tag),
        .ramp_active(ramp_active), .amp_code(amp_code)
    );

    // Reference model state
    logic [RAMP_W-1:0] m_lo, m_hi, m_rs, m_fs, m_w;
    logic [DIV_W-1:0]  m_rd, m_fd, m_cr, m_cf;
    logic              m_dh, m_dl, m_act, m_up, m_s1, m_s2, m_prev;
    logic [1:0]        m_dest;

    function automatic logic [RAMP_W-1:0] exp_up(logic [RAMP_W-1:0] w, logic [RAMP_W-1:0] s, logic [RAMP_W-1:0] h);
        logic [RAMP_W:0] sum = {1'b0, w} + {1'b0, s};
        return (sum >= {1'b0, h}) ? h : sum[RAMP_W-1:0];
    endfunction

    function automatic logic [RAMP_W-1:0] exp_dn(logic [RAMP_W-1:0] w, logic [RAMP_W-1:0] s, logic [RAMP_W-1:0] l);
        logic [RAMP_W:0] lim = {1'b0, l} + {1'b0, s};
        return ({1'b0, w} <= lim) ? l : (w - s);
    endfunction

    function automatic logic [AMP_W-1:0] exp_amp(logic [1:0] d, logic [RAMP_W-1:0] w);
        return (d == 2'd2) ? w[RAMP_W-1 -: AMP_W] : '0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_lo <= '0; m_hi <= '0; m_rs <= '0; m_fs <= '0; m_w <= '0;
            m_rd <= '0; m_fd <= '0; m_cr <= '0; m_cf <= '0;
            m_dh <= 0; m_dl <= 0; m_act <= 0; m_up <= 0;
            m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_dest <= '0;
        end else begin
            logic rt, ft, edg;
            m_s1 <= dir_pin; m_s2 <= m_s1; m_prev <= m_s2;
            edg = m_s2 != m_prev;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_lo <= wr_data;
                    3'd1: m_hi <= wr_data;
                    3'd2: m_rs <= wr_data;
                    3'd3: m_fs <= wr_data;
                    3'd4: m_rd <= wr_data[DIV_W-1:0];
                    3'd5: m_fd <= wr_data[DIV_W-1:0];
                    3'd6: begin m_dh <= wr_data[0]; m_dl <= wr_data[1]; end
                    default: if (wr_data[1:0] != 2'd3) begin
                        if (wr_data[2]) begin m_act <= 1; m_dest <= wr_data[1:0]; end
                        else if (wr_data[1:0] == m_dest) m_act <= 0;
                    end
                endcase
            end
            if (!m_act) begin
                m_cr <= '0; m_cf <= '0; m_w <= m_lo; m_up <= m_s2;
            end else begin
                rt = (m_cr == m_rd);
                ft = (m_cf == m_fd);
                m_cr <= rt ? '0 : m_cr + 1'b1;
                m_cf <= ft ? '0 : m_cf + 1'b1;
                if (m_up && rt) m_w <= exp_up(m_w, m_rs, m_hi);
                else if (!m_up && ft) m_w <= exp_dn(m_w, m_fs, m_lo);
                if (edg) m_up <= m_s2;
                else if (m_up && m_w == m_hi && !m_dh) m_up <= 0;
                else if (!m_up && m_w == m_lo && !m_dl) m_up <= 1;
            end
        end
    end

    // Per-cycle comparison against the model (R4, R5, R6 and others via cur_req)
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (ramp_word !== m_w || ramp_active !== m_act || dest_tag !== m_dest
                || amp_code !== exp_amp(m_dest, m_w)) begin
                errors++;
                $display("FAIL %s: word=%0d act=%0b tag=%0d amp=%0d expected word=%0d act=%0b tag=%0d amp=%0d",
                         cur_req, ramp_word, ramp_active, dest_tag, amp_code,
                         m_w, m_act, m_dest, exp_amp(m_dest, m_w));
            end
        end
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lo_n, hi_n, hits_hi, hits_lo;
        logic [31:0] prevw;
        void'($urandom(32'd20240611));
        cyc(3);
        rst = 0;
        cyc(1);
        // R1 reset state
        check("R1", ramp_word, 0);
        check("R1", ramp_active, 0);
        check("R1", dest_tag, 0);
        check("R1", amp_code, 0);

        // R12: disabled word follows the lower limit
        cur_req = "R12";
        wr(3'd0, 32'd555);
        cyc(1);
        check("R12", ramp_word, 555);

        // R7 / R10 / R4: dwell on both limits, pin high -> rise and hold at upper
        cur_req = "R7";
        wr(3'd0, 32'd100); wr(3'd1, 32'd1000);
        wr(3'd2, 32'd70);  wr(3'd4, 32'd3);
        wr(3'd3, 32'd90);  wr(3'd5, 32'd1);
        wr(3'd6, 32'd3);
        dir_pin = 1; cyc(4);
        wr(3'd7, 32'h4);          // enable, frequency
        check("R2", ramp_active, 1);
        cyc(100);
        check("R6", ramp_word, 1000);
        cyc(50);
        check("R7", ramp_word, 1000);
        dir_pin = 0; cyc(60);
        check("R5", ramp_word, 100);
        cyc(40);
        check("R7", ramp_word, 100);

        // R2: enabling phase replaces frequency
        cur_req = "R2";
        wr(3'd7, 32'h5);
        check("R2", dest_tag, 1);
        // R3: disabling frequency while phase is active has no effect
        cur_req = "R3";
        wr(3'd7, 32'h0);
        check("R3", ramp_active, 1);
        check("R3", dest_tag, 1);
        // code 3 is ignored
        wr(3'd7, 32'h7);
        check("R2", dest_tag, 1);

        // R8: upper without dwell, lower with dwell -> single shot up-and-back
        cur_req = "R8";
        wr(3'd6, 32'd2);
        dir_pin = 1; cyc(150);
        check("R8", ramp_word, 100);
        check("R8", dir_pin, 1);

        // R9: triangle with both dwell flags clear
        cur_req = "R9";
        wr(3'd7, 32'h1);                  // disable phase
        cyc(1);
        check("R3", ramp_active, 0);
        wr(3'd0, 32'd0); wr(3'd1, 32'd400);
        wr(3'd2, 32'd40); wr(3'd4, 32'd0);
        wr(3'd3, 32'd100); wr(3'd5, 32'd2);
        wr(3'd6, 32'd0);
        wr(3'd7, 32'h6);                  // enable, amplitude
        hits_hi = 0; hits_lo = 0; prevw = ramp_word;
        for (int i = 0; i < 200; i++) begin
            cyc(1);
            if (ramp_word == 400 && prevw != 400) hits_hi++;
            if (ramp_word == 0 && prevw != 0) hits_lo++;
            prevw = ramp_word;
            if (i == 5) check("R11", amp_code, {18'd0, ramp_word[31:18]});
        end
        checks++;
        if (hits_hi < 3 || hits_lo < 3) begin
            errors++;
            $display("FAIL R9: actual=%0d/%0d turns expected>=3/3", hits_hi, hits_lo);
        end

        // R11: large word in amplitude mode
        cur_req = "R11";
        wr(3'd7, 32'h2);
        wr(3'd0, 32'hABCD_0000);
        cyc(1);
        check("R11", amp_code, 32'hABCD_0000 >> 18);
        wr(3'd7, 32'h4);
        check("R11", amp_code, 0);
        wr(3'd7, 32'h0);

        // Random phase against the model
        cur_req = "R6";
        for (int it = 0; it < 40; it++) begin
            logic [31:0] lo_r;
            wr(3'd7, {29'd0, 1'b0, dest_tag});
            lo_r = $urandom & 32'h7FFF_FFFF;
            wr(3'd0, lo_r);
            wr(3'd1, lo_r + ($urandom % 100000) + 1);
            wr(3'd2, ($urandom % 9000) + 1);
            wr(3'd3, ($urandom % 9000) + 1);
            wr(3'd4, $urandom % 6);
            wr(3'd5, $urandom % 6);
            wr(3'd6, $urandom % 4);
            dir_pin = $urandom % 2;
            wr(3'd7, 32'h4 | ($urandom % 3));
            for (int k = 0; k < 300; k++) begin
                if ($urandom % 40 == 0) dir_pin = ~dir_pin;
                if ($urandom % 97 == 0) wr(3'd7, {30'd0, 2'(dest_tag + 2'd1) % 2'd3});
                else cyc(1);
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule